// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip sink for a stream of 32-bit trace words. Once software turns capture on, every valid trace word is written into a RAM at the write pointer, and the pointer wraps around the RAM so that the most recent history is kept. A flag records that the pointer has wrapped, which tells software where the oldest word lives: at address 0 when the flag is clear, at the write pointer when it is set.

Capture can be ended in two ways. A trigger input, when stop-on-trigger is armed, starts a countdown of further words to store, and capture halts when the countdown is spent. A manual flush, requested through a self-clearing control bit, can also halt capture when stop-on-flush is armed. With frame formatting on, each stop fills the partial 4-word frame with zero words so that the write pointer ends on a frame boundary. Software reads the buffer back through a data register that returns the word at the read pointer and advances it. Software can also store words through a write-data register and set either pointer to any value.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, control reads 0, the depth register (offset 0x004) reads the RAM depth (16 by default), status (0x00C) reads 0, both pointers read 0 and flush status (0x300) reads 2 (stopped).
- R2: A write to the write-data register (0x024) stores the word at the write pointer (0x018) and advances the pointer by one, modulo the depth.
- R3: A read of the read-data register (0x010) returns, on reg_rdata one cycle later, the word at the read pointer (0x014) and advances the pointer by one, modulo the depth.
- R4: Software may write any value to the read and write pointers, and reads them back unchanged.
- R5: Control (0x020) bit 0 enables capture; while it is 0, trace words are ignored and the write pointer does not move.
- R6: Status bit 0 (full) sets when a stored word carries the write pointer from the last address to 0; a write to the write pointer or a 0-to-1 write of the capture enable clears it.
- R7: With flush-control (0x304) bit 13 set, a trigger starts a countdown from the trigger-count register (0x01C); the word taken in the trigger cycle is not counted, exactly that many further words are stored, then capture halts. Status bit 1 reads 1 once triggered and the count register reads the remaining words.
- R8: With flush-control bit 0 (formatting) set, every halt or flush during capture first stores zero words until the write pointer is a multiple of 4; trace words arriving meanwhile are dropped.
- R9: Writing 1 to flush-control bit 6 starts a flush; bit 6 (and flush-status bit 0) read 1 until the flush completes and then clear by themselves.
- R10: With flush-control bit 12 set, a completed flush during capture halts capture; without it capture continues.
- R11: Flush-status bit 1 reads 1 exactly when capture is off or halted and no zero-fill is in progress.
- R12: The capture_active output is 1 while capture is enabled and not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_valid | input | 1 | Trace word present this cycle |
| trace_data | input | 32 | Trace word |
| trigger_in | input | 1 | Trigger event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| capture_active | output | 1 | Capture enabled and not halted |

## Verification
A wrong pointer shows at once as a wrong value in the pointer registers and, a read later, as a misplaced word at the read-data port; a full flag set or cleared on the wrong store is visible in the next status read. A countdown that is one off leaves the final write pointer one word away from k+1+N (rounded up to the frame when formatting), and a word beyond that point or a nonzero fill word exposes it in the read-back sweep. A flush state machine that hangs keeps bit 6 at 1, which a bounded poll catches within a few cycles.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int OFS_W = 12;

  localparam logic [OFS_W-1:0] OFS_DEPTH = 12'h004;
  localparam logic [OFS_W-1:0] OFS_STAT  = 12'h00C;
  localparam logic [OFS_W-1:0] OFS_RDAT  = 12'h010;
  localparam logic [OFS_W-1:0] OFS_RPTR  = 12'h014;
  localparam logic [OFS_W-1:0] OFS_WPTR  = 12'h018;
  localparam logic [OFS_W-1:0] OFS_TCNT  = 12'h01C;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 12'h020;
  localparam logic [OFS_W-1:0] OFS_WDAT  = 12'h024;
  localparam logic [OFS_W-1:0] OFS_FSTAT = 12'h300;
  localparam logic [OFS_W-1:0] OFS_FCTRL = 12'h304;

  localparam int FC_FMT     = 0;
  localparam int FC_FLUSH   = 6;
  localparam int FC_STOPFL  = 12;
  localparam int FC_STOPTRG = 13;

  typedef struct packed {
    logic fmt_en;
    logic stop_on_flush;
    logic stop_on_trig;
  } fctl_t;
endpackage

// File: rtl/trs_ram.sv
module trs_ram #(
  parameter int DATA_W = 32,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/trs_pointers.sv
module trs_pointers #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          store,
  input  logic          wptr_load,
  input  logic          rptr_load,
  input  logic [AW-1:0] load_val,
  input  logic          rd_adv,
  input  logic          full_clr,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] wptr_nxt,
  output logic          full
);
  always_comb begin
    if (wptr_load)  wptr_nxt = load_val;
    else if (store) wptr_nxt = wptr + 1'b1;
    else            wptr_nxt = wptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      full <= 1'b0;
    end else begin
      wptr <= wptr_nxt;
      if (rptr_load)   rptr <= load_val;
      else if (rd_adv) rptr <= rptr + 1'b1;
      if (wptr_load || full_clr)  full <= 1'b0;
      else if (store && (&wptr))  full <= 1'b1;
    end
  end
endmodule

// File: rtl/trs_capture_ctl.sv
module trs_capture_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_en,
  input  logic             ctl_rise,
  input  trs_pkg::fctl_t   fctl,
  input  logic             flush_start,
  input  logic             trace_valid,
  input  logic             trigger_in,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             sw_block,
  input  logic             aligned_nxt,
  output logic             cap_store,
  output logic             pad_store,
  output logic             active,
  output logic             padding,
  output logic             stopped,
  output logic             flush_busy,
  output logic             triggered,
  output logic             halted,
  output logic [CNT_W-1:0] count
);
  logic pad_halt, pad_flush;
  logic trig_due, trig_start, flush_eval, start_any, need_halt, pad_done;

  assign active     = ctl_en && !halted;
  assign trig_due   = fctl.stop_on_trig && triggered && (count == '0);
  assign flush_eval = flush_busy && !padding;
  assign trig_start = active && !padding && trig_due;
  assign start_any  = flush_eval || trig_start;
  assign need_halt  = trig_start || (flush_eval && fctl.stop_on_flush && active);

  assign cap_store = active && !padding && !flush_busy && trace_valid &&
                     !trig_due && !sw_block;
  assign pad_store = active && padding && !sw_block;
  assign pad_done  = pad_store && aligned_nxt;
  assign stopped   = !active && !padding;

  always_ff @(posedge clk) begin
    if (rst) begin
      halted     <= 1'b0;
      padding    <= 1'b0;
      pad_halt   <= 1'b0;
      pad_flush  <= 1'b0;
      flush_busy <= 1'b0;
      triggered  <= 1'b0;
      count      <= '0;
    end else begin
      if (flush_start && !flush_busy) flush_busy <= 1'b1;

      if (active && fctl.stop_on_trig && trigger_in && !triggered && !padding)
        triggered <= 1'b1;

      if (cnt_load)
        count <= cnt_val;
      else if (cap_store && triggered && (count != '0))
        count <= count - 1'b1;

      if (start_any) begin
        if (active && fctl.fmt_en && !aligned_nxt) begin
          padding   <= 1'b1;
          pad_halt  <= need_halt;
          pad_flush <= flush_eval;
        end else begin
          if (need_halt)  halted     <= 1'b1;
          if (flush_eval) flush_busy <= 1'b0;
        end
      end

      if (padding && !active) begin
        padding <= 1'b0;
        if (pad_flush) flush_busy <= 1'b0;
      end else if (pad_done) begin
        padding <= 1'b0;
        if (pad_halt)  halted     <= 1'b1;
        if (pad_flush) flush_busy <= 1'b0;
      end

      if (ctl_rise) begin
        halted    <= 1'b0;
        triggered <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trs_regif.sv
module trs_regif #(
  parameter int DATA_W = 32,
  parameter int AW     = 4,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [trs_pkg::OFS_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  input  logic                     full,
  input  logic                     triggered,
  input  logic [CNT_W-1:0]         count,
  input  logic                     flush_busy,
  input  logic                     stopped,
  input  logic [AW-1:0]            rptr,
  input  logic [AW-1:0]            wptr,
  input  logic [DATA_W-1:0]        ram_q,
  output logic                     ctl_en,
  output logic                     ctl_rise,
  output trs_pkg::fctl_t           fctl,
  output logic                     flush_start,
  output logic                     wptr_load,
  output logic                     rptr_load,
  output logic [AW-1:0]            load_val,
  output logic                     cnt_load,
  output logic [CNT_W-1:0]         cnt_val,
  output logic                     sw_store,
  output logic [DATA_W-1:0]        sw_data,
  output logic                     rd_adv,
  output logic [DATA_W-1:0]        reg_rdata
);
  import trs_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic              ctl_wr, fctl_wr;
  logic              ram_sel;
  logic [DATA_W-1:0] hold, rd_mux;

  assign ctl_wr      = reg_wr && (reg_addr == OFS_CTRL);
  assign fctl_wr     = reg_wr && (reg_addr == OFS_FCTRL);
  assign ctl_rise    = ctl_wr && reg_wdata[0] && !ctl_en;
  assign flush_start = fctl_wr && reg_wdata[FC_FLUSH];
  assign wptr_load   = reg_wr && (reg_addr == OFS_WPTR);
  assign rptr_load   = reg_wr && (reg_addr == OFS_RPTR);
  assign load_val    = reg_wdata[AW-1:0];
  assign cnt_load    = reg_wr && (reg_addr == OFS_TCNT);
  assign cnt_val     = reg_wdata[CNT_W-1:0];
  assign sw_store    = reg_wr && (reg_addr == OFS_WDAT);
  assign sw_data     = reg_wdata;
  assign rd_adv      = reg_rd && (reg_addr == OFS_RDAT);

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_DEPTH: rd_mux = DATA_W'(DEPTH);
      OFS_STAT:  rd_mux = {{(DATA_W-2){1'b0}}, triggered, full};
      OFS_RPTR:  rd_mux = {{(DATA_W-AW){1'b0}}, rptr};
      OFS_WPTR:  rd_mux = {{(DATA_W-AW){1'b0}}, wptr};
      OFS_TCNT:  rd_mux = {{(DATA_W-CNT_W){1'b0}}, count};
      OFS_CTRL:  rd_mux = {{(DATA_W-1){1'b0}}, ctl_en};
      OFS_FSTAT: rd_mux = {{(DATA_W-2){1'b0}}, stopped, flush_busy};
      OFS_FCTRL: begin
        rd_mux[FC_FMT]     = fctl.fmt_en;
        rd_mux[FC_FLUSH]   = flush_busy;
        rd_mux[FC_STOPFL]  = fctl.stop_on_flush;
        rd_mux[FC_STOPTRG] = fctl.stop_on_trig;
      end
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en  <= 1'b0;
      fctl    <= '0;
      ram_sel <= 1'b0;
      hold    <= '0;
    end else begin
      if (ctl_wr) ctl_en <= reg_wdata[0];
      if (fctl_wr) begin
        fctl.fmt_en        <= reg_wdata[FC_FMT];
        fctl.stop_on_flush <= reg_wdata[FC_STOPFL];
        fctl.stop_on_trig  <= reg_wdata[FC_STOPTRG];
      end
      if (reg_rd) begin
        ram_sel <= rd_adv;
        hold    <= rd_mux;
      end
    end
  end

  assign reg_rdata = ram_sel ? ram_q : hold;
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink #(
  parameter int DATA_W     = 32,
  parameter int DEPTH_LOG2 = 4,
  parameter int FRAME_LOG2 = 2,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trace_valid,
  input  logic [DATA_W-1:0] trace_data,
  input  logic              trigger_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [11:0]       reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              capture_active
);
  localparam int AW = DEPTH_LOG2;

  logic              ctl_en, ctl_rise, flush_start;
  trs_pkg::fctl_t    fctl;
  logic              wptr_load, rptr_load, cnt_load, sw_store, rd_adv;
  logic [AW-1:0]     load_val, wptr, rptr, wptr_nxt;
  logic [CNT_W-1:0]  cnt_val, count;
  logic [DATA_W-1:0] sw_data, ram_q, store_data;
  logic              full, cap_store, pad_store, active, padding, stopped;
  logic              flush_busy, triggered, halted, store_any, sw_block, aligned_nxt;

  assign sw_block    = sw_store || wptr_load;
  assign store_any   = sw_store || cap_store || pad_store;
  assign aligned_nxt = (wptr_nxt[FRAME_LOG2-1:0] == '0);

  always_comb begin
    if (sw_store)       store_data = sw_data;
    else if (cap_store) store_data = trace_data;
    else                store_data = '0;
  end

  trs_regif #(.DATA_W(DATA_W), .AW(AW), .CNT_W(CNT_W)) u_regif (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .full(full), .triggered(triggered), .count(count),
    .flush_busy(flush_busy), .stopped(stopped), .rptr(rptr), .wptr(wptr),
    .ram_q(ram_q), .ctl_en(ctl_en), .ctl_rise(ctl_rise), .fctl(fctl),
    .flush_start(flush_start), .wptr_load(wptr_load), .rptr_load(rptr_load),
    .load_val(load_val), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .sw_store(sw_store), .sw_data(sw_data), .rd_adv(rd_adv), .reg_rdata(reg_rdata)
  );

  trs_pointers #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .store(store_any), .wptr_load(wptr_load),
    .rptr_load(rptr_load), .load_val(load_val), .rd_adv(rd_adv),
    .full_clr(ctl_rise), .wptr(wptr), .rptr(rptr), .wptr_nxt(wptr_nxt), .full(full)
  );

  trs_capture_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .ctl_rise(ctl_rise), .fctl(fctl),
    .flush_start(flush_start), .trace_valid(trace_valid), .trigger_in(trigger_in),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .sw_block(sw_block),
    .aligned_nxt(aligned_nxt), .cap_store(cap_store), .pad_store(pad_store),
    .active(active), .padding(padding), .stopped(stopped), .flush_busy(flush_busy),
    .triggered(triggered), .halted(halted), .count(count)
  );

  trs_ram #(.DATA_W(DATA_W), .AW(AW)) u_ram (
    .clk(clk), .we(store_any), .waddr(wptr), .wdata(store_data),
    .re(rd_adv), .raddr(rptr), .q(ram_q)
  );

  assign capture_active = active;
endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
  parameter int AW         = 4,
  parameter int FRAME_LOG2 = 2,
  parameter int CNT_W      = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             store_any,
  input logic             wptr_load,
  input logic [AW-1:0]    wptr,
  input logic             full,
  input logic             ctl_en,
  input logic             cap_store,
  input logic             halted,
  input logic             fmt_en,
  input logic             padding,
  input logic             flush_busy,
  input logic             triggered,
  input logic             cnt_load,
  input logic [CNT_W-1:0] count
);
  assert_wptr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (store_any && !wptr_load) |=> (wptr == AW'($past(wptr) + 1'b1)));

  assert_no_store_off_R5: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |-> !cap_store);

  assert_full_on_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> (&$past(wptr)));

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!triggered && !cnt_load) |=> $stable(count));

  assert_halt_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(halted) && fmt_en && !$past(wptr_load)) |-> (wptr[FRAME_LOG2-1:0] == '0));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(flush_busy) |-> !padding);
endmodule

bind trace_ring_sink trs_checker #(.AW(DEPTH_LOG2), .FRAME_LOG2(FRAME_LOG2), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .store_any(store_any), .wptr_load(wptr_load), .wptr(wptr),
  .full(full), .ctl_en(ctl_en), .cap_store(cap_store), .halted(halted),
  .fmt_en(fctl.fmt_en), .padding(padding), .flush_busy(flush_busy),
  .triggered(triggered), .cnt_load(cnt_load), .count(count)
);

// File: tb/sim_trace_ring_sink.sv
`timescale 1ns/1ps
module sim_trace_ring_sink;
  localparam int DEPTH = 16;
  localparam logic [11:0] A_DEPTH = 12'h004, A_STAT = 12'h00C, A_RDAT = 12'h010,
    A_RPTR = 12'h014, A_WPTR = 12'h018, A_TCNT = 12'h01C, A_CTRL = 12'h020,
    A_WDAT = 12'h024, A_FSTAT = 12'h300, A_FCTRL = 12'h304;

  logic clk = 1'b0, rst = 1'b1;
  logic trace_valid = 1'b0, trigger_in = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] trace_data = '0, reg_wdata = '0, reg_rdata;
  logic [11:0] reg_addr = '0;
  logic capture_active;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  trace_ring_sink u0 (
    .clk(clk), .rst(rst), .trace_valid(trace_valid), .trace_data(trace_data),
    .trigger_in(trigger_in), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .capture_active(capture_active)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic stream(input int n, input logic [31:0] base, input int trig_at);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trace_valid = 1'b1; trace_data = base + i; trigger_in = (i == trig_at);
    end
    @(negedge clk); trace_valid = 1'b0; trigger_in = 1'b0;
  endtask

  task automatic fill_ones();
    wr(A_WPTR, 0);
    for (int i = 0; i < DEPTH; i++) wr(A_WDAT, 32'hFFFF_FFFF);
    wr(A_WPTR, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_CTRL, rv);  check("R1 ctrl", rv, 0);
    rd(A_DEPTH, rv); check("R1 depth", rv, DEPTH);
    rd(A_STAT, rv);  check("R1 status", rv, 0);
    rd(A_RPTR, rv);  check("R1 rptr", rv, 0);
    rd(A_WPTR, rv);  check("R1 wptr", rv, 0);
    rd(A_FSTAT, rv); check("R1 fstat", rv, 2);
    check("R12 reset capture_active", capture_active, 0);

    // R2, R6: software writes fill whole RAM and wrap
    for (int i = 0; i < DEPTH; i++) wr(A_WDAT, 32'h5500_0000 + i * 3);
    rd(A_WPTR, rv); check("R2 wptr wrapped", rv, 0);
    rd(A_STAT, rv); check("R6 full after wrap", rv & 1, 1);

    // R3 read back with wrap of read pointer
    wr(A_RPTR, 0);
    for (int i = 0; i < DEPTH + 2; i++) begin
      rd(A_RDAT, rv); check("R3 read data", rv, 32'h5500_0000 + (i % DEPTH) * 3);
    end
    rd(A_RPTR, rv); check("R3 rptr wrap", rv, 2);

    // R4, R6: pointer writes
    for (int v = 0; v < DEPTH; v += 5) begin
      wr(A_RPTR, v); rd(A_RPTR, rv); check("R4 rptr load", rv, v);
      wr(A_WPTR, v); rd(A_WPTR, rv); check("R4 wptr load", rv, v);
    end
    rd(A_STAT, rv); check("R6 full cleared by wptr write", rv & 1, 0);

    // R5: disabled capture ignores trace
    wr(A_WPTR, 7);
    stream(5, 32'h1111_0000, -1);
    rd(A_WPTR, rv); check("R5 ignored when off", rv, 7);

    // R5, R12: basic capture
    wr(A_WPTR, 0); wr(A_FCTRL, 0); wr(A_CTRL, 1);
    check("R12 active on", capture_active, 1);
    rd(A_FSTAT, rv); check("R11 running not stopped", rv, 0);
    stream(6, 32'h2222_0000, -1);
    wr(A_CTRL, 0);
    rd(A_WPTR, rv); check("R5 six captured", rv, 6);
    wr(A_RPTR, 0);
    for (int i = 0; i < 6; i++) begin
      rd(A_RDAT, rv); check("R5 captured word", rv, 32'h2222_0000 + i);
    end

    // R6: wrapped capture, oldest at wptr; enable rise clears full
    wr(A_WPTR, 0); wr(A_CTRL, 1);
    stream(20, 32'h3333_0000, -1);
    wr(A_CTRL, 0);
    rd(A_WPTR, rv); check("R6 wptr after wrap", rv, 4);
    rd(A_STAT, rv); check("R6 full set", rv & 1, 1);
    wr(A_RPTR, 4);
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_RDAT, rv); check("R6 oldest-first order", rv, 32'h3333_0004 + i);
    end
    wr(A_CTRL, 1);
    rd(A_STAT, rv); check("R6 cleared by enable", rv & 1, 0);
    wr(A_CTRL, 0);

    // R7, R8, R11, R12: trigger stop sweep
    for (int fmt = 0; fmt < 2; fmt++) begin
      for (int cnt = 0; cnt < 7; cnt++) begin
        int k, n, np;
        logic [31:0] base;
        k = 1 + (cnt % 3);
        n = k + 1 + cnt;
        np = (fmt != 0) ? ((n + 3) / 4) * 4 : n;
        base = 32'h4000_0000 + (fmt << 8) + (cnt << 4);
        wr(A_CTRL, 0);
        fill_ones();
        wr(A_FCTRL, (1 << 13) | fmt);
        wr(A_TCNT, cnt);
        wr(A_CTRL, 1);
        stream(14, base, k);
        repeat (4) @(negedge clk);
        check("R12 halted after trigger", capture_active, 0);
        rd(A_WPTR, rv); check("R7 R8 final wptr", rv, np);
        rd(A_STAT, rv); check("R7 triggered flag", rv, 2);
        rd(A_TCNT, rv); check("R7 count spent", rv, 0);
        rd(A_FSTAT, rv); check("R11 stopped after trigger", rv, 2);
        wr(A_RPTR, 0);
        for (int i = 0; i < np + 1 && i < DEPTH; i++) begin
          logic [31:0] e;
          e = (i < n) ? base + i : (i < np) ? 32'h0 : 32'hFFFF_FFFF;
          rd(A_RDAT, rv); check("R7 R8 stored content", rv, e);
        end
      end
    end

    // R9, R10, R8: flush with stop, unaligned pointer
    wr(A_CTRL, 0); fill_ones();
    wr(A_FCTRL, (1 << 12) | 1);
    wr(A_CTRL, 1);
    stream(5, 32'h6600_0000, -1);
    wr(A_FCTRL, (1 << 12) | (1 << 6) | 1);
    rd(A_FCTRL, rv); check("R9 flush busy reads 1", rv, (1 << 12) | (1 << 6) | 1);
    begin
      int polls = 0;
      do begin rd(A_FCTRL, rv); polls++; end while (rv[6] && polls < 20);
    end
    check("R9 flush self-clears", rv, (1 << 12) | 1);
    check("R10 halted by flush", capture_active, 0);
    rd(A_FSTAT, rv); check("R11 stopped after flush", rv, 2);
    rd(A_WPTR, rv);  check("R8 flush fill to frame", rv, 8);
    wr(A_RPTR, 5);
    for (int i = 5; i < 9; i++) begin
      rd(A_RDAT, rv); check("R8 fill words", rv, (i < 8) ? 32'h0 : 32'hFFFF_FFFF);
    end

    // R10: flush without stop keeps capturing
    wr(A_CTRL, 0); wr(A_WPTR, 0); wr(A_FCTRL, 1); wr(A_CTRL, 1);
    stream(4, 32'h7700_0000, -1);
    wr(A_FCTRL, (1 << 6) | 1);
    repeat (3) @(negedge clk);
    rd(A_FCTRL, rv); check("R9 aligned flush done", rv, 1);
    check("R10 still capturing", capture_active, 1);
    rd(A_FSTAT, rv); check("R11 not stopped", rv, 0);
    stream(2, 32'h7700_0010, -1);
    rd(A_WPTR, rv); check("R10 capture continues", rv, 6);

    // R9: flush while disabled
    wr(A_CTRL, 0);
    wr(A_FCTRL, (1 << 6));
    repeat (2) @(negedge clk);
    rd(A_FSTAT, rv); check("R9 idle flush done", rv, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule